// File: doc/BRIEF.md
# MDIO Management Master

This block is a serial management master that reads and writes 16-bit registers inside external PHY devices over the two-wire MDC/MDIO interface. It divides the system clock down to produce MDC. It builds each management frame: a preamble of ones, the start pattern, an opcode, two 5-bit addresses, a turnaround and a 16-bit data field. It shifts the frame out on MDIO through an output value and a separate output enable, so the pad tri-state buffer stays outside the block.

The host presents a request with a read/write flag, a PHY address, a register address and write data. The block accepts the request only while `busy` is low and runs exactly one frame at a time. When the frame finishes, `done` pulses for one clock. On a read, the received 16-bit word appears on `rdData` and stays there until the next read completes. The MDC half period is derived from the system clock frequency parameter, so the high phase, the low phase and the full period all respect the interface timing limits.

Top module: `mdio_master`

## Requirements
- R1: Each MDC high phase and each MDC low phase lasts exactly HALF system clocks, where HALF = ceil(SYS_CLK_MHZ*200/1000) with a minimum of 1. Each phase is therefore at least 200 ns (meeting the 160 ns minimum), and the MDC period is at least 400 ns (at most 2.5 MHz).
- R2: While `busy` is low, `mdc` is 0 and `mdioOe` is 0.
- R3: A frame is 64 MDC cycles, one bit per cycle, and a new bit is presented at each falling MDC edge. Bits 0..31 are all ones (preamble) and bits 32..33 are 0 then 1 (start).
- R4: Bits 34..35 carry the opcode: 1,0 for a read and 0,1 for a write.
- R5: Bits 36..40 carry the PHY address and bits 41..45 carry the register address, each most significant bit first.
- R6: On a write, bits 46..47 are 1 then 0, bits 48..63 carry the write data MSB first, and `mdioOe` is 1 for all 64 bits.
- R7: On a read, `mdioOe` is 1 for bits 0..45 and 0 for bits 46..63. The master samples `mdioIn` at the MDC rising edge of bits 48..63 and assembles the samples MSB first into the read word.
- R8: A request is accepted on a clock edge where `reqValid` is 1 and `busy` is 0. A request raised while `busy` is 1 is ignored and does not alter the frame in progress.
- R9: `done` is high for exactly one clock, 128*HALF clocks after the accepting edge. It coincides with the final falling MDC edge and with `busy` returning to 0.
- R10: `rdData` changes only on the clock where a read's `done` is high. It holds its value across later writes and until the next read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqPhy | input | 5 | PHY address |
| reqReg | input | 5 | Register address |
| reqWdata | input | 16 | Data for a write |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-clock pulse at frame end |
| rdData | output | 16 | Last word read |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Value driven on MDIO when enabled |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | Value seen on the MDIO line |

## Verification
After an accepting edge, `busy` and the low phase of bit 0 appear one clock later. Every MDC edge then falls on a multiple of HALF clocks from that edge, and `done` is due exactly 128*HALF clocks after acceptance. The bench samples on the falling system clock edge. It counts clocks from the accepting edge, so it can demand `done` in that exact cycle and require it to be gone one cycle later. It records MDIO and the enable at each observed MDC rise and measures the length of every MDC phase. It changes the modeled PHY line only just after an MDC fall, so every value is settled a full phase before the rising edge where the master samples it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TA_POS    = FRAME_LEN - DATA_W - 2;
  localparam int DATA_POS  = FRAME_LEN - DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  // control-to-datapath strobes
  typedef struct packed {
    logic load;    // capture request into frame register
    logic shift;   // advance to next frame bit (falling MDC)
    logic sample;  // take mdioIn (rising MDC, read data bits)
    logic commit;  // publish received word
  } mdioStrb_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mdioState_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_CLKS = 50
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqRead,
  output mdioStrb_t strb,
  output logic      busy,
  output logic      done,
  output logic      mdc,
  output logic      mdioOe
);
  localparam int CNT_W = $clog2(HALF_CLKS + 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CLKS - 1);
  localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_IDX    = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(DATA_POS);

  mdioState_t       state;
  logic [CNT_W-1:0] phaseCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             mdcR;
  logic             readR;
  logic             doneR;
  logic             halfEnd;
  logic             lastFall;

  always_comb begin
    halfEnd     = (state == ST_RUN) && (phaseCnt == HALF_LAST);
    lastFall    = halfEnd && mdcR && (bitIdx == LAST_BIT);
    strb.load   = (state == ST_IDLE) && reqValid;
    strb.shift  = halfEnd && mdcR && (bitIdx != LAST_BIT);
    strb.sample = halfEnd && !mdcR && readR && (bitIdx >= DATA_IDX);
    strb.commit = lastFall && readR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitIdx   <= '0;
      mdcR     <= 1'b0;
      readR    <= 1'b0;
      doneR    <= 1'b0;
    end else begin
      doneR <= lastFall;
      case (state)
        ST_IDLE: begin
          mdcR     <= 1'b0;
          phaseCnt <= '0;
          bitIdx   <= '0;
          if (reqValid) begin
            state <= ST_RUN;
            readR <= reqRead;
          end
        end
        ST_RUN: begin
          if (halfEnd) begin
            phaseCnt <= '0;
            if (!mdcR) begin
              mdcR <= 1'b1;
            end else begin
              mdcR <= 1'b0;
              if (bitIdx == LAST_BIT) begin
                state  <= ST_IDLE;
                bitIdx <= '0;
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state == ST_RUN);
  assign done   = doneR;
  assign mdc    = mdcR;
  assign mdioOe = busy && !(readR && (bitIdx >= TA_IDX));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrb_t         strb,
  input  logic              reqRead,
  input  logic [ADDR_W-1:0] reqPhy,
  input  logic [ADDR_W-1:0] reqReg,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic [DATA_W-1:0] rdData
);
  logic [FRAME_LEN-1:0] frameSr;
  logic [DATA_W-1:0]    rxSr;
  logic [DATA_W-1:0]    rdHold;
  logic [FRAME_LEN-1:0] frameInit;
  logic [1:0]           opCode;
  logic [1:0]           taCode;
  logic [DATA_W-1:0]    dataField;

  always_comb begin
    opCode    = reqRead ? 2'b10 : 2'b01;
    taCode    = reqRead ? 2'b11 : 2'b10;
    dataField = reqRead ? '1 : reqWdata;
    frameInit = {{PRE_LEN{1'b1}}, 2'b01, opCode, reqPhy, reqReg, taCode, dataField};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameSr <= '0;
      rxSr    <= '0;
      rdHold  <= '0;
    end else begin
      if (strb.load)
        frameSr <= frameInit;
      else if (strb.shift)
        frameSr <= {frameSr[FRAME_LEN-2:0], 1'b0};
      if (strb.sample)
        rxSr <= {rxSr[DATA_W-2:0], mdioIn};
      if (strb.commit)
        rdHold <= rxSr;
    end
  end

  assign mdioOut = frameSr[FRAME_LEN-1];
  assign rdData  = rdHold;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int SYS_CLK_MHZ = 250
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqRead,
  input  logic [4:0]  reqPhy,
  input  logic [4:0]  reqReg,
  input  logic [15:0] reqWdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  localparam int HALF_RAW  = (SYS_CLK_MHZ * 200 + 999) / 1000;
  localparam int HALF_CLKS = (HALF_RAW < 1) ? 1 : HALF_RAW;

  mdioStrb_t strb;

  mdio_ctrl #(.HALF_CLKS(HALF_CLKS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqRead (reqRead),
    .strb    (strb),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdioOe  (mdioOe)
  );

  mdio_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqRead (reqRead),
    .reqPhy  (reqPhy),
    .reqReg  (reqReg),
    .reqWdata(reqWdata),
    .mdioIn  (mdioIn),
    .mdioOut (mdioOut),
    .rdData  (rdData)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdioOe,
  input logic        mdioOut,
  input logic [15:0] rdData
);
  // R2
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $fell(mdc)));

  // R3
  frame_starts_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (mdioOe && mdioOut && !mdc));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> done);

  // R1
  mdc_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busy   (busy),
  .done   (done),
  .mdc    (mdc),
  .mdioOe (mdioOe),
  .mdioOut(mdioOut),
  .rdData (rdData)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  localparam int SYS_MHZ = 10;
  localparam int HALF    = (SYS_MHZ * 200 + 999) / 1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqRead = 1'b0;
  logic [4:0]  reqPhy = '0;
  logic [4:0]  reqReg = '0;
  logic [15:0] reqWdata = '0;
  logic        busy, done, mdc, mdioOut, mdioOe;
  logic [15:0] rdData;
  logic        mdioIn = 1'b1;

  int total = 0;
  int bad = 0;

  // monitor state
  logic        prevMdc = 1'b0;
  logic        prevBusy = 1'b0;
  int          lvlCnt = 0;
  int          phaseErr = 0;
  int          rises = 0;
  logic [63:0] seenOut, seenOe;
  logic        curRead = 1'b0;
  logic [15:0] phyWord = '0;

  always #2 clk = ~clk;

  mdio_master #(.SYS_CLK_MHZ(SYS_MHZ)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqPhy(reqPhy), .reqReg(reqReg), .reqWdata(reqWdata),
    .busy(busy), .done(done), .rdData(rdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // line monitor and PHY model
  always @(negedge clk) begin
    if (busy && !prevBusy) begin
      lvlCnt = 1;
    end else if (mdc == prevMdc) begin
      lvlCnt++;
    end else begin
      if (prevBusy && lvlCnt != HALF) phaseErr++;
      lvlCnt = 1;
      if (mdc) begin
        if (rises < 64) begin
          seenOut[63-rises] = mdioOut;
          seenOe[63-rises]  = mdioOe;
        end
        rises++;
      end else begin
        if (rises == 47) mdioIn = 1'b0;
        else if (rises >= 48 && rises < 64 && curRead) mdioIn = phyWord[63-rises];
        else mdioIn = 1'b1;
      end
    end
    prevMdc  = mdc;
    prevBusy = busy;
  end

  task automatic runTxn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, input bit poke);
    logic [63:0] expF;
    logic [15:0] prevRd;
    int m;
    prevRd   = rdData;
    curRead  = rd;
    phyWord  = {phy, rg, ~phy, 1'b1};
    rises    = 0;
    phaseErr = 0;
    mdioIn   = 1'b1;
    seenOut  = '0;
    seenOe   = '0;
    @(negedge clk);
    reqValid = 1'b1; reqRead = rd; reqPhy = phy; reqReg = rg; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    m = 0;
    while (!done && m < 200 * HALF) begin
      @(negedge clk);
      m++;
      if (poke && m == 7) begin
        // R8: request while busy must be ignored
        reqValid = 1'b1; reqRead = ~rd; reqPhy = ~phy; reqReg = ~rg; reqWdata = ~wd;
      end else begin
        reqValid = 1'b0;
      end
    end
    reqValid = 1'b0;
    // R9 done timing
    check(done && m == 128 * HALF, "R9 done latency", 64'(m), 64'(128 * HALF));
    expF = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, wd};
    // R3 R4 R5 R8 header bits
    check(seenOut[63:18] == expF[63:18], "R3/R4/R5/R8 header", {18'd0, seenOut[63:18]}, {18'd0, expF[63:18]});
    // R1 phase lengths
    check(phaseErr == 0 && rises == 64, "R1 phase length", 64'(phaseErr), 64'd0);
    if (rd) begin
      // R7 enable pattern and data
      check(seenOe == {46'h3FFF_FFFF_FFFF, 18'd0}, "R7 oe", seenOe, {46'h3FFF_FFFF_FFFF, 18'd0});
      check(rdData == phyWord, "R7 rdData", 64'(rdData), 64'(phyWord));
    end else begin
      // R6 write TA, data, enable
      check(seenOut[17:0] == expF[17:0] && seenOe == '1, "R6 write tail", {seenOe[45:0], seenOut[17:0]}, {46'h3FFF_FFFF_FFFF, expF[17:0]});
      // R10 rdData held across write
      check(rdData == prevRd, "R10 hold", 64'(rdData), 64'(prevRd));
    end
    @(negedge clk);
    // R9 single pulse, R2 idle
    check(!done && !busy, "R9 pulse width", {62'd0, done, busy}, 64'd0);
    check(!mdc && !mdioOe, "R2 idle", {62'd0, mdc, mdioOe}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check(!busy && !done && !mdc && !mdioOe && rdData == 16'h0, "R2 reset",
          {45'd0, busy, done, mdc, mdioOe, rdData}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      runTxn(1'b1, 5'(i), 5'(31 - i), 16'h0, (i % 4) == 0);
      runTxn(1'b0, 5'(i), 5'(i) ^ 5'h15, {5'(i), ~5'(i), 6'h2A}, (i % 4) == 1);
    end
    // boundary data values on writes
    runTxn(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 1'b0);
    runTxn(1'b0, 5'h00, 5'h00, 16'h0000, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule